// File: doc/BRIEF.md
# Priority Event Queue Scanner

This block serves a set of event rings, one per priority level, on behalf of a processor. Each ring marks live entries with a generation bit that flips on every lap of its storage, so no shared fill count is needed between the producer and the consumer. Pushing an entry into a ring also marks that priority as pending. The block holds a pending-priority mask and a current priority threshold register, here called the CPPR.

A scan request walks the pending bits from index 0, the most favoured, toward higher indices. The block examines one ring per clock. An empty ring loses its pending bit and the walk moves on. The walk stops at the first live entry. At the end the block reports the entry and its priority, or zero with priority 0xFF if it found nothing, and loads the CPPR with that priority. A scan can peek, which leaves the read pointers alone, or consume the entry.

Each ring also has two accounting counters. The occupancy count is raised when a new source is assigned to the ring. The deferred count collects sources that have since been moved away. The deferred count is taken off the occupancy only at a moment when the ring is seen empty, so a slot is never released while a moved source's event may still sit in it.

Top module: `psq_scanner`

## Requirements
- R1: A scan picks the lowest-index set pending bit first, stops at the first ring whose head entry is live, and reports that entry on `data_o` and its index on `prio_o` with a one-cycle `done_o` pulse.
- R2: A pending ring found empty during a scan has its pending bit cleared and the walk continues with the next set bit, one ring per clock; `busy_o` is high while walking.
- R3: When no pending ring holds an entry, the scan reports `data_o` = 0 and `prio_o` = 0xFF.
- R4: A peek scan (`peek_i` = 1 at request) returns the head entry without advancing any read pointer; a consuming scan advances the read pointer of the ring it returns from.
- R5: On `done_o` the CPPR (`cppr_o`) holds the reported priority; `cppr_wr_o` pulses in that cycle only if the value changed. An idle-time write through `cppr_set_i`/`cppr_val_i` behaves the same way.
- R6: `deliver_o` is high when the lowest set pending index is strictly below `cppr_o`, so a CPPR of 0 blocks all delivery and 0xFF allows all.
- R7: Entries of one ring come out in push order across any number of laps of its DEPTH-entry storage; a live entry is one whose stored generation bit differs from the consumer's lap bit.
- R8: `claim_i` raises the occupancy count of ring `claim_prio_i` by one, up to DEPTH-1; further claims are ignored. The occupancy of ring q is `occ_o[q*CW +: CW]`, with CW = log2(DEPTH)+1.
- R9: `move_i` raises the deferred count of ring `move_prio_i` (`defer_o[q*CW +: CW]`). The deferred count is subtracted from the occupancy and cleared only when a scan finds that ring pending and empty.
- R10: If a deferred count exceeds the occupancy at that moment, the occupancy becomes 0 and `err_o` is set and stays set until reset.
- R11: `scan_i` and `cppr_set_i` are ignored while `busy_o` is high; a push to a ring sets its pending bit, and a push wins over a clear of the same bit in the same cycle.
- R12: After reset the CPPR is 0xFF, the pending mask and all counters are 0, and `done_o`, `busy_o`, `deliver_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push an entry into a ring |
| push_prio_i | input | PW | Ring index for the push |
| push_data_i | input | DW | Entry payload |
| claim_i | input | 1 | Raise the occupancy count of a ring |
| claim_prio_i | input | PW | Ring index for the claim |
| move_i | input | 1 | Raise the deferred count of a ring |
| move_prio_i | input | PW | Ring index for the move |
| scan_i | input | 1 | Start a scan |
| peek_i | input | 1 | Scan without consuming |
| cppr_set_i | input | 1 | Write the CPPR while idle |
| cppr_val_i | input | 8 | Value for the CPPR write |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | Scan result valid, one cycle |
| data_o | output | DW | Entry found, or 0 |
| prio_o | output | 8 | Priority found, or 0xFF |
| cppr_o | output | 8 | Current CPPR |
| cppr_wr_o | output | 1 | CPPR value changed this cycle |
| deliver_o | output | 1 | A pending priority beats the CPPR |
| pend_o | output | NQ | Pending-priority mask |
| occ_o | output | NQ*CW | Occupancy counts, ring q at q*CW |
| defer_o | output | NQ*CW | Deferred counts, ring q at q*CW |
| err_o | output | 1 | Sticky accounting underflow |

## Verification
The scan is driven with several pending patterns. Rings are filled in scrambled order, so the reported priority shows whether the walk follows index order or push order. Some pending rings are already drained, which shows whether an empty ring loses its pending bit and the walk carries on. A peek is followed by a repeat peek and then a consume of the same entry, which tells a pointer that stayed put from one that moved. A single ring is pushed and drained for more than one lap of its storage to exercise the generation bit. The accounting counters are driven so the fold happens once after a scan that found an entry, when it must not fire, and once after a scan that found the ring empty, when it must. One case starts with a deferred count larger than the occupancy, which must trip the error flag.

// File: rtl/psq_pkg.sv
package psq_pkg;
  typedef enum logic [0:0] {ST_IDLE, ST_SCAN} psq_state_e;
  localparam logic [7:0] PRIO_NONE = 8'hFF;
endpackage

// File: rtl/psq_ring.sv
module psq_ring #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          adv_i,
  output logic          head_vld_o,
  output logic [DW-1:0] head_data_o
);
  localparam int IW = $clog2(DEPTH);

  logic [DEPTH-1:0] gen_q;
  logic [DW-1:0]    mem_q [DEPTH];
  logic [IW-1:0]    wp_q, rp_q;
  logic             wgen_q, tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_q  <= '0;
      wp_q   <= '0;
      wgen_q <= 1'b1;
      rp_q   <= '0;
      tog_q  <= 1'b0;
    end else begin
      if (push_i) begin
        gen_q[wp_q] <= wgen_q;
        wp_q        <= wp_q + 1'b1;
        if (wp_q == IW'(DEPTH - 1)) wgen_q <= ~wgen_q;
      end
      if (adv_i) begin
        rp_q <= rp_q + 1'b1;
        if (rp_q == IW'(DEPTH - 1)) tog_q <= ~tog_q;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= push_data_i;
  end

  // live when the stored generation differs from the consumer lap bit
  assign head_vld_o  = gen_q[rp_q] != tog_q;
  assign head_data_o = mem_q[rp_q];
endmodule

// File: rtl/psq_acct.sv
module psq_acct #(
  parameter int CW      = 4,
  parameter int OCC_MAX = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          claim_i,
  input  logic          move_i,
  input  logic          fold_i,
  output logic [CW-1:0] occ_o,
  output logic [CW-1:0] def_o,
  output logic          ovf_o
);
  logic [CW-1:0] occ_q, def_q, occ_b, def_b, occ_n, def_n;

  always_comb begin
    occ_b = occ_q;
    def_b = def_q;
    ovf_o = 1'b0;
    if (fold_i) begin
      if (def_q > occ_q) begin
        occ_b = '0;
        ovf_o = 1'b1;
      end else begin
        occ_b = occ_q - def_q;
      end
      def_b = '0;
    end
    occ_n = occ_b;
    if (claim_i && (occ_b < CW'(OCC_MAX))) occ_n = occ_b + 1'b1;
    def_n = def_b;
    if (move_i && (def_b != '1)) def_n = def_b + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q <= '0;
      def_q <= '0;
    end else begin
      occ_q <= occ_n;
      def_q <= def_n;
    end
  end

  assign occ_o = occ_q;
  assign def_o = def_q;
endmodule

// File: rtl/psq_scanner.sv
module psq_scanner
  import psq_pkg::*;
#(
  parameter int NQ    = 8,
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  localparam int PW   = $clog2(NQ),
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [PW-1:0]    push_prio_i,
  input  logic [DW-1:0]    push_data_i,
  input  logic             claim_i,
  input  logic [PW-1:0]    claim_prio_i,
  input  logic             move_i,
  input  logic [PW-1:0]    move_prio_i,
  input  logic             scan_i,
  input  logic             peek_i,
  input  logic             cppr_set_i,
  input  logic [7:0]       cppr_val_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DW-1:0]    data_o,
  output logic [7:0]       prio_o,
  output logic [7:0]       cppr_o,
  output logic             cppr_wr_o,
  output logic             deliver_o,
  output logic [NQ-1:0]    pend_o,
  output logic [NQ*CW-1:0] occ_o,
  output logic [NQ*CW-1:0] defer_o,
  output logic             err_o
);
  localparam int OCC_MAX = DEPTH - 1;

  psq_state_e    st_q;
  logic [NQ-1:0] pend_q, pend_n;
  logic          peek_q, done_q, cppr_wr_q, err_q;
  logic [DW-1:0] data_q, res_data;
  logic [7:0]    prio_q, cppr_q, res_prio, sel_ext;
  logic [PW-1:0] sel;
  logic          any, scanning, hit, miss, fin;

  logic [NQ-1:0] head_vld, adv, fold, ovf;
  logic [DW-1:0] head_dat [NQ];

  // lowest set pending bit
  always_comb begin
    sel = '0;
    for (int i = NQ - 1; i >= 0; i--) begin
      if (pend_q[i]) sel = PW'(i);
    end
  end

  assign any      = |pend_q;
  assign sel_ext  = {{(8 - PW){1'b0}}, sel};
  assign scanning = (st_q == ST_SCAN);
  assign hit      = scanning && any && head_vld[sel];
  assign miss     = scanning && any && !head_vld[sel];
  assign fin      = scanning && (hit || !any);
  assign res_prio = hit ? sel_ext : PRIO_NONE;
  assign res_data = hit ? head_dat[sel] : '0;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic          push_q_w;
    logic [CW-1:0] occ_w, def_w;

    assign push_q_w = push_i && (push_prio_i == PW'(q));
    assign adv[q]   = hit && !peek_q && (sel == PW'(q));
    assign fold[q]  = miss && (sel == PW'(q));

    psq_ring #(.DW(DW), .DEPTH(DEPTH)) ring_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_i     (push_q_w),
      .push_data_i(push_data_i),
      .adv_i      (adv[q]),
      .head_vld_o (head_vld[q]),
      .head_data_o(head_dat[q])
    );

    psq_acct #(.CW(CW), .OCC_MAX(OCC_MAX)) acct_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .claim_i(claim_i && (claim_prio_i == PW'(q))),
      .move_i (move_i && (move_prio_i == PW'(q))),
      .fold_i (fold[q]),
      .occ_o  (occ_w),
      .def_o  (def_w),
      .ovf_o  (ovf[q])
    );

    assign occ_o[q*CW +: CW]   = occ_w;
    assign defer_o[q*CW +: CW] = def_w;
    // push wins over an empty-clear in the same cycle
    assign pend_n[q] = push_q_w | (pend_q[q] & ~fold[q]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      pend_q    <= '0;
      peek_q    <= 1'b0;
      done_q    <= 1'b0;
      data_q    <= '0;
      prio_q    <= PRIO_NONE;
      cppr_q    <= PRIO_NONE;
      cppr_wr_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      pend_q    <= pend_n;
      done_q    <= fin;
      cppr_wr_q <= 1'b0;
      if (|ovf) err_q <= 1'b1;
      if (!scanning && scan_i) begin
        st_q   <= ST_SCAN;
        peek_q <= peek_i;
      end else if (fin) begin
        st_q <= ST_IDLE;
      end
      if (fin) begin
        data_q    <= res_data;
        prio_q    <= res_prio;
        cppr_q    <= res_prio;
        cppr_wr_q <= (res_prio != cppr_q);
      end else if (!scanning && cppr_set_i) begin
        cppr_q    <= cppr_val_i;
        cppr_wr_q <= (cppr_val_i != cppr_q);
      end
    end
  end

  assign busy_o    = scanning;
  assign done_o    = done_q;
  assign data_o    = data_q;
  assign prio_o    = prio_q;
  assign cppr_o    = cppr_q;
  assign cppr_wr_o = cppr_wr_q;
  assign deliver_o = any && (sel_ext < cppr_q);
  assign pend_o    = pend_q;
  assign err_o     = err_q;
endmodule

// File: rtl/psq_scanner_chk.sv
module psq_scanner_chk #(
  parameter int NQ = 8,
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic [DW-1:0] data_o,
  input logic [7:0]    prio_o,
  input logic [7:0]    cppr_o,
  input logic          cppr_wr_o,
  input logic          deliver_o,
  input logic          err_o
);
  a_r1_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r1_prio_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && prio_o != 8'hFF) |-> (prio_o < 8'(NQ)));
  a_r2_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r3_empty_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && prio_o == 8'hFF) |-> (data_o == '0));
  a_r5_cppr_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cppr_o == prio_o));
  a_r5_wr_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cppr_wr_o |-> (cppr_o != $past(cppr_o)));
  a_r6_block_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cppr_o == 8'h00) |-> !deliver_o);
  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind psq_scanner psq_scanner_chk #(.NQ(NQ), .DW(DW)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .data_o   (data_o),
  .prio_o   (prio_o),
  .cppr_o   (cppr_o),
  .cppr_wr_o(cppr_wr_o),
  .deliver_o(deliver_o),
  .err_o    (err_o)
);

// File: tb/psq_scanner_tb_top.sv
`timescale 1ns/1ps
module psq_scanner_tb_top;
  localparam int NQ = 8, DEPTH = 8, DW = 16, PW = 3, CW = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic push_i = 0, claim_i = 0, move_i = 0, scan_i = 0, peek_i = 0, cppr_set_i = 0;
  logic [PW-1:0] push_prio_i = '0, claim_prio_i = '0, move_prio_i = '0;
  logic [DW-1:0] push_data_i = '0;
  logic [7:0] cppr_val_i = '0;
  logic busy_o, done_o, cppr_wr_o, deliver_o, err_o;
  logic [DW-1:0] data_o;
  logic [7:0] prio_o, cppr_o;
  logic [NQ-1:0] pend_o;
  logic [NQ*CW-1:0] occ_o, defer_o;

  int n_vec = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  psq_scanner #(.NQ(NQ), .DEPTH(DEPTH), .DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .push_i(push_i), .push_prio_i(push_prio_i), .push_data_i(push_data_i),
    .claim_i(claim_i), .claim_prio_i(claim_prio_i),
    .move_i(move_i), .move_prio_i(move_prio_i),
    .scan_i(scan_i), .peek_i(peek_i),
    .cppr_set_i(cppr_set_i), .cppr_val_i(cppr_val_i),
    .busy_o(busy_o), .done_o(done_o), .data_o(data_o), .prio_o(prio_o),
    .cppr_o(cppr_o), .cppr_wr_o(cppr_wr_o), .deliver_o(deliver_o),
    .pend_o(pend_o), .occ_o(occ_o), .defer_o(defer_o), .err_o(err_o)
  );

  // op(2) prio(3) peek(1) data(16) exp_data(16) exp_prio(8); op 0 = push, 1 = scan
  localparam int NV = 19;
  localparam logic [45:0] VEC [NV] = '{
    {2'd0, 3'd3, 1'b0, 16'h0033, 16'h0000, 8'h00},
    {2'd0, 3'd1, 1'b0, 16'h0011, 16'h0000, 8'h00},
    {2'd0, 3'd5, 1'b0, 16'h0055, 16'h0000, 8'h00},
    {2'd1, 3'd0, 1'b0, 16'h0000, 16'h0011, 8'h01}, // R1 favoured first
    {2'd1, 3'd0, 1'b1, 16'h0000, 16'h0033, 8'h03}, // R2 skip drained p1, R4 peek
    {2'd1, 3'd0, 1'b0, 16'h0000, 16'h0033, 8'h03}, // R4 peek left pointer
    {2'd1, 3'd0, 1'b0, 16'h0000, 16'h0055, 8'h05},
    {2'd1, 3'd0, 1'b0, 16'h0000, 16'h0000, 8'hFF}, // R3
    {2'd0, 3'd0, 1'b0, 16'h000A, 16'h0000, 8'h00},
    {2'd0, 3'd0, 1'b0, 16'h000B, 16'h0000, 8'h00},
    {2'd1, 3'd0, 1'b0, 16'h0000, 16'h000A, 8'h00}, // R1 priority 0
    {2'd1, 3'd0, 1'b0, 16'h0000, 16'h000B, 8'h00},
    {2'd1, 3'd0, 1'b0, 16'h0000, 16'h0000, 8'hFF}, // R3
    {2'd0, 3'd7, 1'b0, 16'h0077, 16'h0000, 8'h00},
    {2'd0, 3'd2, 1'b0, 16'h0022, 16'h0000, 8'h00},
    {2'd1, 3'd0, 1'b1, 16'h0000, 16'h0022, 8'h02}, // R4
    {2'd1, 3'd0, 1'b1, 16'h0000, 16'h0022, 8'h02}, // R4
    {2'd1, 3'd0, 1'b0, 16'h0000, 16'h0022, 8'h02},
    {2'd1, 3'd0, 1'b0, 16'h0000, 16'h0077, 8'h07}  // R2 drained p2 skipped
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [PW-1:0] p, input logic [DW-1:0] d);
    @(negedge clk); push_i = 1; push_prio_i = p; push_data_i = d;
    @(negedge clk); push_i = 0;
  endtask

  task automatic claim(input logic [PW-1:0] p, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); claim_i = 1; claim_prio_i = p;
    end
    @(negedge clk); claim_i = 0;
  endtask

  task automatic move(input logic [PW-1:0] p, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); move_i = 1; move_prio_i = p;
    end
    @(negedge clk); move_i = 0;
  endtask

  task automatic set_cppr(input logic [7:0] v);
    @(negedge clk); cppr_set_i = 1; cppr_val_i = v;
    @(negedge clk); cppr_set_i = 0;
  endtask

  task automatic scan(input logic pk, output logic [DW-1:0] d, output logic [7:0] p,
                      output logic wr);
    d = '0; p = 8'h00; wr = 1'b0;
    @(negedge clk); scan_i = 1; peek_i = pk;
    @(negedge clk); scan_i = 0;
    for (int k = 0; k < 40; k++) begin
      if (done_o) begin
        d = data_o; p = prio_o; wr = cppr_wr_o;
        break;
      end
      @(negedge clk);
    end
  endtask

  function automatic logic [CW-1:0] occ_of(input int q);
    return occ_o[q*CW +: CW];
  endfunction
  function automatic logic [CW-1:0] def_of(input int q);
    return defer_o[q*CW +: CW];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic [7:0] p;
    logic wr;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 cppr", {24'h0, cppr_o}, 32'hFF);
    check("R12 flags", {28'h0, done_o, busy_o, deliver_o, err_o}, 32'h0);
    check("R12 pend", {24'h0, pend_o}, 32'h0);
    check("R12 counters", occ_o | defer_o, 32'h0);
    rst_ni = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][45:44] == 2'd0) begin
        push(VEC[v][43:41], VEC[v][39:24]);
      end else begin
        scan(VEC[v][40], d, p, wr);
        check($sformatf("R1 vec%0d data", v), {16'h0, d}, {16'h0, VEC[v][23:8]});
        check($sformatf("R1 vec%0d prio", v), {24'h0, p}, {24'h0, VEC[v][7:0]});
        check($sformatf("R5 vec%0d cppr", v), {24'h0, cppr_o}, {24'h0, VEC[v][7:0]});
      end
    end

    // R5 write only on change
    scan(1'b0, d, p, wr);
    check("R3 final empty", {24'h0, p}, 32'hFF);
    check("R5 wr on change", {31'h0, wr}, 32'h1);
    scan(1'b0, d, p, wr);
    check("R5 no wr same value", {31'h0, wr}, 32'h0);

    // R6 delivery gate, R11 push sets pending
    push(3'd4, 16'h0044);
    check("R11 pend set", {24'h0, pend_o}, 32'h10);
    check("R6 open", {31'h0, deliver_o}, 32'h1);
    set_cppr(8'h00);
    check("R6 closed", {31'h0, deliver_o}, 32'h0);
    set_cppr(8'h05);
    check("R6 above", {31'h0, deliver_o}, 32'h1);
    set_cppr(8'h04);
    check("R6 equal", {31'h0, deliver_o}, 32'h0);
    scan(1'b0, d, p, wr);
    check("R1 p4 data", {16'h0, d}, 32'h44);
    scan(1'b0, d, p, wr);

    // R8, R9 accounting
    claim(3'd2, 3);
    check("R8 occ", {28'h0, occ_of(2)}, 32'd3);
    move(3'd2, 2);
    check("R9 defer held", {28'h0, def_of(2)}, 32'd2);
    push(3'd2, 16'h002A);
    scan(1'b0, d, p, wr);
    check("R9 no fold on hit occ", {28'h0, occ_of(2)}, 32'd3);
    check("R9 no fold on hit def", {28'h0, def_of(2)}, 32'd2);
    scan(1'b0, d, p, wr);
    check("R9 fold occ", {28'h0, occ_of(2)}, 32'd1);
    check("R9 fold def", {28'h0, def_of(2)}, 32'd0);
    check("R10 no err yet", {31'h0, err_o}, 32'h0);

    // R10 underflow
    claim(3'd6, 1);
    move(3'd6, 3);
    push(3'd6, 16'h0066);
    scan(1'b0, d, p, wr);
    scan(1'b0, d, p, wr);
    check("R10 occ sat", {28'h0, occ_of(6)}, 32'd0);
    check("R10 err", {31'h0, err_o}, 32'h1);
    repeat (3) @(negedge clk);
    check("R10 err sticky", {31'h0, err_o}, 32'h1);

    // R8 cap at DEPTH-1
    claim(3'd0, 9);
    check("R8 cap", {28'h0, occ_of(0)}, 32'd7);

    // R7 generation bit across laps
    for (int i = 0; i < 12; i++) begin
      push(3'd1, 16'h0100 + 16'(i));
      scan(1'b0, d, p, wr);
      check($sformatf("R7 lap item %0d", i), {16'h0, d}, 32'h0100 + i);
    end
    scan(1'b0, d, p, wr);
    check("R7 drained", {24'h0, p}, 32'hFF);

    // R11 cppr write ignored while busy
    push(3'd3, 16'h003C);
    @(negedge clk); scan_i = 1; peek_i = 0;
    @(negedge clk); scan_i = 0; cppr_set_i = 1; cppr_val_i = 8'h00;
    check("R2 busy", {31'h0, busy_o}, 32'h1);
    @(negedge clk); cppr_set_i = 0;
    check("R11 done", {31'h0, done_o}, 32'h1);
    check("R11 cppr kept", {24'h0, cppr_o}, 32'h03);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule